// File: doc/BRIEF.md
# LDPC Variable-Node Unreliability Selector

This block runs one scoring pass over the variable nodes of a small LDPC code each time a decoding iteration asks for one. The parity-check matrix is fixed by a parameter. The block takes the current signed LLR of every variable node and the LLR that node had one iteration earlier. From these it forms hard decisions and evaluates every parity check. For each node it counts how many of its checks fail, and it measures how far the node's LLR moved. The failed-check count and the movement are each scaled by a programmable weight and added into one saturating score per node.

A node is marked active when its score is strictly above a programmable threshold and it is also among the K highest-scoring such nodes. The surrounding decoder spends its message-update effort only on the active nodes. The same pass raises a completion flag when the hard decisions satisfy every check, or when the iteration count supplied by the caller has reached its limit.

Top module: `vn_unrel_selector`

## Requirements
- R1: A node's hard decision is 1 when its current LLR is negative (sign bit set) and 0 otherwise, so an LLR of exactly zero decides 0.
- R2: Check c fails when the XOR of the hard decisions of the nodes it connects is 1. With the default 8-node, 4-check matrix, check 0 connects nodes {0,1,2,4}, check 1 connects {0,1,3,5}, check 2 connects {0,2,3,6} and check 3 connects {1,2,3,7}. Bit c*N+v of the matrix parameter is set when check c connects node v.
- R3: A node's unreliability count is the number of failed checks that connect to it.
- R4: A node's innovation is the magnitude of (current LLR − previous LLR), taken as two's-complement values.
- R5: A node's score is w_unsat·count + w_innov·innovation, clamped to 2^MET_W−1 (1023 by default) rather than wrapping.
- R6: A node can be active only if its score is strictly greater than `thresh_i`.
- R7: At most K nodes (3 by default) are active. When more nodes qualify, the highest scores win, and equal scores are resolved in favour of the lower node index.
- R8: `done_o` is 1 in the result cycle when every check is satisfied, or when `iter_cnt_i >= iter_max_i` at the start sample.
- R9: The inputs are sampled on the clock edge at which `start_i` is high. `valid_o` pulses for exactly one cycle, two edges later. `active_o` and `done_o` carry results only in that cycle and are 0 in every other cycle.
- R10: While reset is high, and after it, until a start has been processed, `valid_o`, `active_o` and `done_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin one scoring pass on the present inputs |
| llr_cur_i | input | N*LLR_W | Current LLRs, node v at bits [v*LLR_W +: LLR_W] |
| llr_prev_i | input | N*LLR_W | Previous-iteration LLRs, same layout |
| w_unsat_i | input | WT_W | Weight of the failed-check count |
| w_innov_i | input | WT_W | Weight of the LLR movement |
| thresh_i | input | MET_W | Score threshold (strict) |
| iter_cnt_i | input | ITER_W | Current iteration number |
| iter_max_i | input | ITER_W | Iteration limit |
| valid_o | output | 1 | One-cycle result strobe |
| active_o | output | N | Active-node mask |
| done_o | output | 1 | Decoding complete |

## Verification
An error in the hard-decision or check logic appears at the ports as a wrong `done_o` for a valid codeword, or as a count that moves the wrong nodes into the mask. Both show up in the same result strobe, two edges after start. A wrong score, a clamp that wraps, or a broken ranking appears as a mask with an extra, missing or swapped bit in that strobe. Directed cases use equal scores and clamped scores to expose errors that random scores would rarely reach. Pipeline-control errors appear as a strobe that is missing, repeated or early, or as a mask that shows outside the strobe.

// File: rtl/vn_sel_pkg.sv
package vn_sel_pkg;

    localparam int DEF_N      = 8;
    localparam int DEF_C      = 4;
    localparam int DEF_K      = 3;
    localparam int DEF_LLR_W  = 8;
    localparam int DEF_WT_W   = 4;
    localparam int DEF_MET_W  = 10;
    localparam int DEF_ITER_W = 8;

    // check c, node v at bit c*N+v
    localparam logic [DEF_C*DEF_N-1:0] DEF_HMAT = {
        8'b1000_1110,
        8'b0100_1101,
        8'b0010_1011,
        8'b0001_0111
    };

    typedef struct packed {
        logic live;
        logic fin;
    } ctl_t;

    function automatic logic hard_of(input logic sign_bit);
        return sign_bit;
    endfunction

endpackage

// File: rtl/vn_syndrome.sv
module vn_syndrome
    import vn_sel_pkg::*;
#(
    parameter int N     = DEF_N,
    parameter int C     = DEF_C,
    parameter int LLR_W = DEF_LLR_W,
    parameter int CNT_W = $clog2(DEF_C + 1),
    parameter logic [C*N-1:0] HMAT = DEF_HMAT
) (
    input  logic [N*LLR_W-1:0] llr_i,
    output logic [N*CNT_W-1:0] cnt_o,
    output logic               all_sat_o
);

    logic [N-1:0] hard;
    logic [C-1:0] fail;

    for (genvar v = 0; v < N; v++) begin : g_hard
        assign hard[v] = hard_of(llr_i[v*LLR_W + LLR_W - 1]);
    end

    for (genvar c = 0; c < C; c++) begin : g_chk
        assign fail[c] = ^(hard & HMAT[c*N +: N]);
    end

    for (genvar v = 0; v < N; v++) begin : g_cnt
        always_comb begin
            logic [CNT_W-1:0] acc;
            acc = '0;
            for (int c = 0; c < C; c++) begin
                if (HMAT[c*N + v] && fail[c]) acc = acc + CNT_W'(1);
            end
            cnt_o[v*CNT_W +: CNT_W] = acc;
        end
    end

    assign all_sat_o = ~|fail;

endmodule

// File: rtl/vn_score.sv
module vn_score
    import vn_sel_pkg::*;
#(
    parameter int N     = DEF_N,
    parameter int LLR_W = DEF_LLR_W,
    parameter int CNT_W = 3,
    parameter int WT_W  = DEF_WT_W,
    parameter int MET_W = DEF_MET_W
) (
    input  logic [N*LLR_W-1:0] cur_i,
    input  logic [N*LLR_W-1:0] prev_i,
    input  logic [N*CNT_W-1:0] cnt_i,
    input  logic [WT_W-1:0]    w_unsat_i,
    input  logic [WT_W-1:0]    w_innov_i,
    input  logic [MET_W-1:0]   thresh_i,
    output logic [N*MET_W-1:0] metric_o,
    output logic [N-1:0]       pass_o
);

    localparam int MAG_W  = LLR_W + 1;
    localparam int BASE_W = (MAG_W > CNT_W) ? MAG_W : CNT_W;
    localparam int SUM_W  = BASE_W + WT_W + 1;
    localparam logic [MET_W-1:0] MET_MAX = '1;

    for (genvar v = 0; v < N; v++) begin : g_node
        logic [MAG_W-1:0] diff;
        logic [MAG_W-1:0] mag;
        logic [SUM_W-1:0] sum;
        logic [MET_W-1:0] met;

        assign diff = {cur_i[v*LLR_W + LLR_W - 1], cur_i[v*LLR_W +: LLR_W]}
                    - {prev_i[v*LLR_W + LLR_W - 1], prev_i[v*LLR_W +: LLR_W]};
        assign mag  = diff[MAG_W-1] ? (~diff + MAG_W'(1)) : diff;
        assign sum  = SUM_W'(cnt_i[v*CNT_W +: CNT_W]) * SUM_W'(w_unsat_i)
                    + SUM_W'(mag) * SUM_W'(w_innov_i);

        if (SUM_W > MET_W) begin : g_clamp
            assign met = (sum > SUM_W'(MET_MAX)) ? MET_MAX : sum[MET_W-1:0];
        end else begin : g_wide
            assign met = MET_W'(sum);
        end

        assign metric_o[v*MET_W +: MET_W] = met;
        assign pass_o[v] = met > thresh_i;
    end

endmodule

// File: rtl/vn_topk_select.sv
module vn_topk_select
    import vn_sel_pkg::*;
#(
    parameter int N     = DEF_N,
    parameter int K     = DEF_K,
    parameter int MET_W = DEF_MET_W
) (
    input  logic [N*MET_W-1:0] metric_i,
    input  logic [N-1:0]       pass_i,
    output logic [N-1:0]       mask_o
);

    localparam int RANK_W = $clog2(N + 1);

    // node i wins when fewer than K qualifying nodes outrank it
    for (genvar i = 0; i < N; i++) begin : g_rank
        always_comb begin
            logic [RANK_W-1:0] above;
            logic [MET_W-1:0]  mi;
            logic [MET_W-1:0]  mj;
            above = '0;
            mi = metric_i[i*MET_W +: MET_W];
            for (int j = 0; j < N; j++) begin
                mj = metric_i[j*MET_W +: MET_W];
                if (j != i && pass_i[j] && ((mj > mi) || (mj == mi && j < i)))
                    above = above + RANK_W'(1);
            end
            mask_o[i] = pass_i[i] && (int'(above) < K);
        end
    end

endmodule

// File: rtl/vn_unrel_selector.sv
module vn_unrel_selector
    import vn_sel_pkg::*;
#(
    parameter int N      = DEF_N,
    parameter int C      = DEF_C,
    parameter int K      = DEF_K,
    parameter int LLR_W  = DEF_LLR_W,
    parameter int WT_W   = DEF_WT_W,
    parameter int MET_W  = DEF_MET_W,
    parameter int ITER_W = DEF_ITER_W,
    parameter logic [C*N-1:0] HMAT = DEF_HMAT
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start_i,
    input  logic [N*LLR_W-1:0]   llr_cur_i,
    input  logic [N*LLR_W-1:0]   llr_prev_i,
    input  logic [WT_W-1:0]      w_unsat_i,
    input  logic [WT_W-1:0]      w_innov_i,
    input  logic [MET_W-1:0]     thresh_i,
    input  logic [ITER_W-1:0]    iter_cnt_i,
    input  logic [ITER_W-1:0]    iter_max_i,
    output logic                 valid_o,
    output logic [N-1:0]         active_o,
    output logic                 done_o
);

    localparam int CNT_W = $clog2(C + 1);

    logic [N*CNT_W-1:0] cnt;
    logic               all_sat;
    logic [N*MET_W-1:0] metric;
    logic [N-1:0]       pass;

    vn_syndrome #(
        .N(N), .C(C), .LLR_W(LLR_W), .CNT_W(CNT_W), .HMAT(HMAT)
    ) u_synd (
        .llr_i     (llr_cur_i),
        .cnt_o     (cnt),
        .all_sat_o (all_sat)
    );

    vn_score #(
        .N(N), .LLR_W(LLR_W), .CNT_W(CNT_W), .WT_W(WT_W), .MET_W(MET_W)
    ) u_score (
        .cur_i     (llr_cur_i),
        .prev_i    (llr_prev_i),
        .cnt_i     (cnt),
        .w_unsat_i (w_unsat_i),
        .w_innov_i (w_innov_i),
        .thresh_i  (thresh_i),
        .metric_o  (metric),
        .pass_o    (pass)
    );

    // stage A: scores
    ctl_t               ctl_a;
    logic [N*MET_W-1:0] metric_a;
    logic [N-1:0]       pass_a;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_a    <= '0;
            metric_a <= '0;
            pass_a   <= '0;
        end else begin
            ctl_a.live <= start_i;
            ctl_a.fin  <= all_sat || (iter_cnt_i >= iter_max_i);
            if (start_i) begin
                metric_a <= metric;
                pass_a   <= pass;
            end
        end
    end

    logic [N-1:0] mask_a;

    vn_topk_select #(
        .N(N), .K(K), .MET_W(MET_W)
    ) u_topk (
        .metric_i (metric_a),
        .pass_i   (pass_a),
        .mask_o   (mask_a)
    );

    // stage B: results
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o  <= 1'b0;
            active_o <= '0;
            done_o   <= 1'b0;
        end else begin
            valid_o  <= ctl_a.live;
            active_o <= ctl_a.live ? mask_a : '0;
            done_o   <= ctl_a.live & ctl_a.fin;
        end
    end

endmodule

// File: rtl/vn_unrel_selector_chk.sv
module vn_unrel_selector_chk #(
    parameter int N      = 8,
    parameter int K      = 3,
    parameter int ITER_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic [ITER_W-1:0] iter_cnt_i,
    input logic [ITER_W-1:0] iter_max_i,
    input logic              valid_o,
    input logic [N-1:0]      active_o,
    input logic              done_o
);

    logic [1:0] age;

    always_ff @(posedge clk) begin
        if (rst) age <= '0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    assert_k_cap_R7: assert property (@(posedge clk) disable iff (rst)
        $countones(active_o) <= K);

    assert_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> (active_o == '0 && !done_o));

    assert_strobe_R9: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd2) |-> (valid_o == $past(start_i, 2)));

    assert_iter_limit_R8: assert property (@(posedge clk) disable iff (rst)
        (start_i && iter_cnt_i >= iter_max_i) |=> ##1 (valid_o && done_o));

    assert_reset_R10: assert property (@(posedge clk)
        $past(rst) |-> (!valid_o && active_o == '0 && !done_o));

endmodule

bind vn_unrel_selector vn_unrel_selector_chk #(
    .N(N), .K(K), .ITER_W(ITER_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .iter_cnt_i (iter_cnt_i),
    .iter_max_i (iter_max_i),
    .valid_o    (valid_o),
    .active_o   (active_o),
    .done_o     (done_o)
);

// File: tb/vn_unrel_selector_bench.sv
module vn_unrel_selector_bench;

    localparam int N = 8;
    localparam int C = 4;
    localparam int K = 3;
    localparam int LW = 8;
    localparam int MW = 10;
    localparam int MMAX = 1023;
    localparam logic [C*N-1:0] HB = {8'b1000_1110, 8'b0100_1101,
                                     8'b0010_1011, 8'b0001_0111};

    logic           clk = 0;
    logic           rst = 1;
    logic           start_i = 0;
    logic [N*LW-1:0] llr_cur_i = '0;
    logic [N*LW-1:0] llr_prev_i = '0;
    logic [3:0]     w_unsat_i = '0;
    logic [3:0]     w_innov_i = '0;
    logic [MW-1:0]  thresh_i = '0;
    logic [7:0]     iter_cnt_i = '0;
    logic [7:0]     iter_max_i = 8'd10;
    logic           valid_o;
    logic [N-1:0]   active_o;
    logic           done_o;

    int n_chk = 0;
    int n_bad = 0;
    bit ended = 0;

    always #5 clk = ~clk;

    vn_unrel_selector u_vn_unrel_selector (
        .clk(clk), .rst(rst), .start_i(start_i),
        .llr_cur_i(llr_cur_i), .llr_prev_i(llr_prev_i),
        .w_unsat_i(w_unsat_i), .w_innov_i(w_innov_i), .thresh_i(thresh_i),
        .iter_cnt_i(iter_cnt_i), .iter_max_i(iter_max_i),
        .valid_o(valid_o), .active_o(active_o), .done_o(done_o)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic model(input logic [N*LW-1:0] cur, input logic [N*LW-1:0] prv,
                         input int wu, input int wi, input int th, input int it, input int im,
                         output logic [N-1:0] mask, output logic dn);
        logic [N-1:0] hb;
        logic [C-1:0] bad;
        int sc [N];
        bit ok [N];
        hb = '0;
        for (int v = 0; v < N; v++) hb[v] = (cur[v*LW +: LW] >= 8'h80);
        for (int c = 0; c < C; c++) begin
            bad[c] = 0;
            for (int v = 0; v < N; v++) if (HB[c*N+v]) bad[c] ^= hb[v];
        end
        for (int v = 0; v < N; v++) begin
            int cnt;
            int d;
            cnt = 0;
            for (int c = 0; c < C; c++) if (HB[c*N+v] && bad[c]) cnt++;
            d = int'($signed(cur[v*LW +: LW])) - int'($signed(prv[v*LW +: LW]));
            if (d < 0) d = -d;
            sc[v] = wu * cnt + wi * d;
            if (sc[v] > MMAX) sc[v] = MMAX;
            ok[v] = sc[v] > th;
        end
        mask = '0;
        for (int r = 0; r < K; r++) begin
            int best;
            best = -1;
            for (int v = 0; v < N; v++)
                if (ok[v] && !mask[v] && (best < 0 || sc[v] > sc[best])) best = v;
            if (best >= 0) mask[best] = 1'b1;
        end
        dn = (bad == '0) || (it >= im);
    endtask

    task automatic pass_run(input logic [N*LW-1:0] cur, input logic [N*LW-1:0] prv,
                            input int wu, input int wi, input int th, input int it,
                            input int im, input string req);
        logic [N-1:0] em;
        logic ed;
        model(cur, prv, wu, wi, th, it, im, em, ed);
        llr_cur_i = cur; llr_prev_i = prv;
        w_unsat_i = 4'(wu); w_innov_i = 4'(wi); thresh_i = MW'(th);
        iter_cnt_i = 8'(it); iter_max_i = 8'(im);
        start_i = 1;
        @(negedge clk); start_i = 0;
        check({req, " R9 early"}, 32'(valid_o), 0);
        @(negedge clk);
        check({req, " R9 strobe"}, 32'(valid_o), 1);
        check({req, " mask"}, 32'(active_o), 32'(em));
        check({req, " R8 done"}, 32'(done_o), 32'(ed));
        @(negedge clk);
        check({req, " R9 one-cycle"}, 32'(valid_o), 0);
        check({req, " R9 idle mask"}, 32'(active_o), 0);
    endtask

    function automatic logic [N*LW-1:0] codeword(input logic [3:0] d, input int mag);
        logic [N-1:0] b;
        logic [N*LW-1:0] r;
        b[3:0] = d;
        b[4] = d[0] ^ d[1] ^ d[2];
        b[5] = d[0] ^ d[1] ^ d[3];
        b[6] = d[0] ^ d[2] ^ d[3];
        b[7] = d[1] ^ d[2] ^ d[3];
        for (int v = 0; v < N; v++) r[v*LW +: LW] = b[v] ? LW'(-mag) : LW'(mag);
        return r;
    endfunction

    initial begin
        int cyc;
        cyc = 0;
        while (cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!ended) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [N*LW-1:0] a;
        logic [N*LW-1:0] b;
        void'($urandom(32'd4242));
        @(negedge clk);
        check("R10 reset valid", 32'(valid_o), 0);
        check("R10 reset mask", 32'(active_o), 0);
        check("R10 reset done", 32'(done_o), 0);
        @(negedge clk); rst = 0;
        @(negedge clk);
        check("R10 after reset", 32'({valid_o, done_o, active_o}), 0);

        // R1: zero LLR decides 0 -> all checks hold
        pass_run('0, '0, 5, 5, 0, 0, 10, "R1 zero llr");
        // R1: -1 on node 4 fails check 0 only -> nodes 0,1,2,4 count 1
        a = '0; a[4*LW +: LW] = 8'hFF;
        pass_run(a, a, 4, 0, 3, 0, 10, "R1 R2 R3 single flip");
        // R2: valid codewords are complete
        pass_run(codeword(4'b1011, 20), '0, 3, 1, 0, 0, 10, "R2 codeword");
        pass_run(codeword(4'b0110, 1), '0, 1, 1, 0, 0, 10, "R2 codeword small");
        // R4 R5: saturation, threshold just below clamp
        a = {N{8'h7F}}; b = {N{8'h80}};
        pass_run(a, b, 15, 15, 1022, 0, 10, "R5 clamp");
        pass_run(a, b, 15, 15, 1023, 0, 10, "R5 R6 clamp strict");
        // R6: strict threshold on exact score
        a = '0; a[2*LW +: LW] = 8'd10;
        pass_run(a, '0, 0, 2, 20, 0, 10, "R6 equal thresh");
        pass_run(a, '0, 0, 2, 19, 0, 10, "R6 above thresh");
        // R7: equal scores -> lowest indices
        a = {N{8'd9}};
        pass_run(a, '0, 0, 3, 0, 0, 10, "R7 ties");
        // R4: negative movement magnitude
        a = '0; b = '0; a[6*LW +: LW] = 8'd5; b[6*LW +: LW] = 8'hF6;
        pass_run(a, b, 0, 1, 14, 0, 10, "R4 magnitude");
        // R8: iteration limit with failing checks
        a = '0; a[0 +: LW] = 8'h90;
        pass_run(a, '0, 1, 1, 0, 7, 7, "R8 iter limit");
        pass_run(a, '0, 1, 1, 0, 6, 7, "R8 below limit");
        // R9: no start, no strobe
        llr_cur_i = {N{8'h33}};
        repeat (3) begin
            @(negedge clk);
            check("R9 no start", 32'(valid_o), 0);
        end

        for (int t = 0; t < 300; t++) begin
            logic [N*LW-1:0] cr;
            logic [N*LW-1:0] pr;
            for (int v = 0; v < N; v++) begin
                cr[v*LW +: LW] = 8'($urandom);
                pr[v*LW +: LW] = 8'($urandom);
            end
            if (t % 5 == 0) cr = codeword(4'($urandom), int'($urandom_range(1, 127)));
            if (t % 7 == 0) pr = cr;
            pass_run(cr, pr, int'($urandom_range(0, 15)), int'($urandom_range(0, 15)),
                     int'($urandom_range(0, 600)), int'($urandom_range(0, 12)),
                     int'($urandom_range(1, 12)), "R3 R4 R5 R6 R7 random");
        end

        ended = 1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule